// File: doc/BRIEF.md
# DMA Hold-Request Cancellation Controller

This block arbitrates bus ownership between a DMA engine and a CPU while interrupts are live. Each interrupt source carries a programmable priority level. The block finds the most urgent pending source and compares its level against a programmable base level. When the pending interrupt is more urgent than that base, the block raises a cancellation request. The cancellation request tells the DMA to give up its bus hold, so that the CPU can service the interrupt.

A software-stepped nesting counter gates the DMA hold request on its way to the CPU. An interrupt handler steps the counter up on entry and down on exit. While any handler is still running, the counter is nonzero. A nonzero counter stops the DMA from taking the bus back before the interrupt source has been cleared.

Levels are `LVL_W` bits wide, and a numerically smaller level is more urgent. The all-ones level marks a source as disabled. Both outputs are registered.

Top module: `hold_cancel_ctrl`

## Requirements
- R1: Every source has its own level register, which resets to all ones (disabled). A write with `lvl_we` stores `lvl_wdata` into the register picked by `lvl_sel`. A select at or above `NUM_SRC` changes nothing.
- R2: A source whose level is all ones never causes `dma_cancel_req`, even when the base level is also all ones.
- R3: The cancellation decision uses the smallest level among the pending, enabled sources. Ties are resolved toward the lower source index.
- R4: `dma_cancel_req` is 1 exactly one clock after a cycle in which the winning level is strictly smaller than the base level. It is 0 after a cycle with no pending enabled source, or with a winning level greater than or equal to the base level.
- R5: The base-level register resets to all ones and is loaded from `base_wdata` when `base_we` is 1.
- R6: `cnt_inc` alone adds one to the nesting counter and saturates at the maximum value (15 for 4 bits). `cnt_dec` alone subtracts one and saturates at 0.
- R7: `cnt_we` loads `cnt_wdata` and takes precedence over the strobes. `cnt_inc` and `cnt_dec` asserted together leave the counter unchanged.
- R8: `cpu_hold_req` is 1 exactly one clock after a cycle in which `dma_hold_req` is 1 and the counter reads zero. A nonzero counter blocks the request.
- R9: While reset is held, `dma_cancel_req` and `cpu_hold_req` are 0 and `cnt_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | NUM_SRC | Pending flag per interrupt source |
| lvl_we | input | 1 | Level register write strobe |
| lvl_sel | input | SEL_W | Source index for the level write |
| lvl_wdata | input | LVL_W | Level value to write |
| base_we | input | 1 | Base-level write strobe |
| base_wdata | input | LVL_W | Base-level value |
| cnt_inc | input | 1 | Nesting counter increment strobe |
| cnt_dec | input | 1 | Nesting counter decrement strobe |
| cnt_we | input | 1 | Nesting counter direct write strobe |
| cnt_wdata | input | CNT_W | Nesting counter write value |
| dma_hold_req | input | 1 | Hold request from the DMA |
| cpu_hold_req | output | 1 | Gated hold request to the CPU |
| dma_cancel_req | output | 1 | Hold cancellation request to the DMA |
| cnt_level | output | CNT_W | Current nesting counter value |

## Verification
The bench builds the block with six sources, a non-power-of-two count. With that value, select codes 6 and 7 exist on the three-bit select bus but name no register, so out-of-range writes can be tried. The resolver loop also runs over a width that does not fill its index space. Levels stay five bits wide and the counter four bits, so the saturation points at 15 and 0 are reached in a few strobes. A level of 31 then equals the reset base level, which puts the strict-compare boundary at the reset state.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
   // Counter operation resolved from the strobes
   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_UP   = 2'd1,
      CNT_DOWN = 2'd2,
      CNT_LOAD = 2'd3
   } cnt_op_e;
endpackage

// File: rtl/hrc_level_regs.sv
module hrc_level_regs #(
   parameter int NUM_SRC = 8,
   parameter int LVL_W   = 5,
   localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [SEL_W-1:0]                sel,
   input  logic [LVL_W-1:0]                wdata,
   output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl
);
   localparam logic [LVL_W-1:0] LVL_OFF = {LVL_W{1'b1}};

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic hit;
      assign hit = we && (sel == SEL_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   lvl[g] <= LVL_OFF;
         else if (hit) lvl[g] <= wdata;
      end
   end
endmodule

// File: rtl/hrc_prio_resolve.sv
module hrc_prio_resolve #(
   parameter int NUM_SRC = 8,
   parameter int LVL_W   = 5,
   localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0]              pend,
   input  logic [NUM_SRC-1:0][LVL_W-1:0]   lvl,
   output logic                            valid,
   output logic [LVL_W-1:0]                win_lvl,
   output logic [SEL_W-1:0]                win_idx
);
   localparam logic [LVL_W-1:0] LVL_OFF = {LVL_W{1'b1}};

   always_comb begin
      valid   = 1'b0;
      win_lvl = LVL_OFF;
      win_idx = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         // strict compare keeps the lower index on a tie
         if (pend[i] && (lvl[i] != LVL_OFF) && (!valid || (lvl[i] < win_lvl))) begin
            valid   = 1'b1;
            win_lvl = lvl[i];
            win_idx = SEL_W'(i);
         end
      end
   end
endmodule

// File: rtl/hrc_nest_counter.sv
module hrc_nest_counter
   import hrc_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   cnt_op_e op;

   always_comb begin
      if (we)                op = CNT_LOAD;
      else if (inc && !dec)  op = CNT_UP;
      else if (dec && !inc)  op = CNT_DOWN;
      else                   op = CNT_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else begin
         unique case (op)
            CNT_LOAD: cnt <= wdata;
            CNT_UP:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            CNT_DOWN: if (cnt != '0)      cnt <= cnt - 1'b1;
            default:  cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/hold_cancel_ctrl.sv
module hold_cancel_ctrl #(
   parameter int NUM_SRC = 8,
   parameter int LVL_W   = 5,
   parameter int CNT_W   = 4,
   localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_pend,
   input  logic               lvl_we,
   input  logic [SEL_W-1:0]   lvl_sel,
   input  logic [LVL_W-1:0]   lvl_wdata,
   input  logic               base_we,
   input  logic [LVL_W-1:0]   base_wdata,
   input  logic               cnt_inc,
   input  logic               cnt_dec,
   input  logic               cnt_we,
   input  logic [CNT_W-1:0]   cnt_wdata,
   input  logic               dma_hold_req,
   output logic               cpu_hold_req,
   output logic               dma_cancel_req,
   output logic [CNT_W-1:0]   cnt_level
);
   initial begin
      if (NUM_SRC < 2)  $error("NUM_SRC must be at least 2");
      if (LVL_W < 2)    $error("LVL_W must be at least 2");
      if (CNT_W < 1)    $error("CNT_W must be at least 1");
   end

   logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
   logic [LVL_W-1:0]              base_lvl;
   logic                          win_valid;
   logic [LVL_W-1:0]              win_lvl;
   logic [SEL_W-1:0]              win_idx;
   logic                          cancel_nxt;
   logic                          gate_open;

   hrc_level_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lvl_we),
      .sel   (lvl_sel),
      .wdata (lvl_wdata),
      .lvl   (src_lvl)
   );

   hrc_prio_resolve #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_res (
      .pend    (irq_pend),
      .lvl     (src_lvl),
      .valid   (win_valid),
      .win_lvl (win_lvl),
      .win_idx (win_idx)
   );

   hrc_nest_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc),
      .dec   (cnt_dec),
      .we    (cnt_we),
      .wdata (cnt_wdata),
      .cnt   (cnt_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       base_lvl <= {LVL_W{1'b1}};
      else if (base_we) base_lvl <= base_wdata;
   end

   assign cancel_nxt = win_valid && (win_lvl < base_lvl);
   assign gate_open  = (cnt_level == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_cancel_req <= 1'b0;
         cpu_hold_req   <= 1'b0;
      end else begin
         dma_cancel_req <= cancel_nxt;
         cpu_hold_req   <= dma_hold_req && gate_open;
      end
   end

   logic unused_idx;
   assign unused_idx = ^win_idx;
endmodule

// File: rtl/hrc_chk.sv
module hrc_chk #(
   parameter int LVL_W = 5,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dma_hold_req,
   input logic             cpu_hold_req,
   input logic             dma_cancel_req,
   input logic [CNT_W-1:0] cnt_level,
   input logic             cnt_inc,
   input logic             cnt_dec,
   input logic             cnt_we,
   input logic             win_valid,
   input logic [LVL_W-1:0] win_lvl,
   input logic [LVL_W-1:0] base_lvl
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   // R8
   gate_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_hold_req && cnt_level == '0) |=> cpu_hold_req);
   // R8
   gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_level != '0) |=> !cpu_hold_req);
   // R4
   cancel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_lvl < base_lvl) |=> dma_cancel_req);
   // R4
   cancel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_valid && win_lvl < base_lvl) |=> !dma_cancel_req);
   // R6
   cnt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_level == CMAX && cnt_inc && !cnt_dec && !cnt_we) |=> cnt_level == CMAX);
   // R6
   cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_level == '0 && cnt_dec && !cnt_inc && !cnt_we) |=> cnt_level == '0);
   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_level != CMAX && cnt_inc && !cnt_dec && !cnt_we) |=> cnt_level == $past(cnt_level) + 1'b1);
   // R7
   cnt_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_inc && cnt_dec && !cnt_we) |=> $stable(cnt_level));
endmodule

bind hold_cancel_ctrl hrc_chk #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .dma_hold_req   (dma_hold_req),
   .cpu_hold_req   (cpu_hold_req),
   .dma_cancel_req (dma_cancel_req),
   .cnt_level      (cnt_level),
   .cnt_inc        (cnt_inc),
   .cnt_dec        (cnt_dec),
   .cnt_we         (cnt_we),
   .win_valid      (win_valid),
   .win_lvl        (win_lvl),
   .base_lvl       (base_lvl)
);

// File: tb/sim_hold_cancel_ctrl.sv
module sim_hold_cancel_ctrl;
   localparam int CLK_PER = 10;
   localparam int NSRC    = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] irq_pend = '0;
   logic       lvl_we = 1'b0;
   logic [2:0] lvl_sel = '0;
   logic [4:0] lvl_wdata = '0;
   logic       base_we = 1'b0;
   logic [4:0] base_wdata = '0;
   logic       cnt_inc = 1'b0, cnt_dec = 1'b0, cnt_we = 1'b0;
   logic [3:0] cnt_wdata = '0;
   logic       dma_hold_req = 1'b0;
   logic       cpu_hold_req, dma_cancel_req;
   logic [3:0] cnt_level;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   hold_cancel_ctrl #(.NUM_SRC(NSRC), .LVL_W(5), .CNT_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend),
      .lvl_we(lvl_we), .lvl_sel(lvl_sel), .lvl_wdata(lvl_wdata),
      .base_we(base_we), .base_wdata(base_wdata),
      .cnt_inc(cnt_inc), .cnt_dec(cnt_dec), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
      .dma_hold_req(dma_hold_req), .cpu_hold_req(cpu_hold_req),
      .dma_cancel_req(dma_cancel_req), .cnt_level(cnt_level)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // two edges: one to load a register, one for the registered output
   task automatic settle();
      @(posedge clk); @(posedge clk); @(negedge clk);
   endtask

   task automatic wr_lvl(input int idx, input int v);
      lvl_sel = 3'(idx); lvl_wdata = 5'(v); lvl_we = 1'b1;
      @(negedge clk); lvl_we = 1'b0;
   endtask

   task automatic wr_base(input int v);
      base_wdata = 5'(v); base_we = 1'b1;
      @(negedge clk); base_we = 1'b0;
   endtask

   task automatic cnt_op(input bit i, input bit d, input bit w, input int v);
      cnt_inc = i; cnt_dec = d; cnt_we = w; cnt_wdata = 4'(v);
      @(negedge clk);
      cnt_inc = 1'b0; cnt_dec = 1'b0; cnt_we = 1'b0;
   endtask

   task automatic t_reset();
      irq_pend = '1; dma_hold_req = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 cancel in reset", dma_cancel_req, 0);
      chk("R9 cpu hold in reset", cpu_hold_req, 0);
      chk("R9 counter in reset", cnt_level, 0);
      rst_n = 1'b1; irq_pend = '0; dma_hold_req = 1'b0;
      settle();
   endtask

   task automatic t_disabled();
      // all levels 31 after reset and base 31: no cancel (R1, R2, R5)
      irq_pend = '1; settle();
      chk("R2 disabled sources, reset base", dma_cancel_req, 0);
      wr_base(31); wr_lvl(0, 31); settle();
      chk("R2 level 31 never cancels", dma_cancel_req, 0);
      irq_pend = '0; settle();
   endtask

   task automatic t_cancel();
      wr_lvl(3, 12); wr_base(10);
      irq_pend = 6'b001000; settle();
      chk("R4 level above base no cancel", dma_cancel_req, 0);
      wr_base(12); settle();
      chk("R4 equal level no cancel", dma_cancel_req, 0);
      wr_base(13); settle();
      chk("R4 level below base cancels", dma_cancel_req, 1);
      irq_pend = '0;
      @(posedge clk); @(negedge clk);
      chk("R4 clears one cycle after pend drops", dma_cancel_req, 0);
      irq_pend = 6'b001000; #1;
      chk("R4 not before edge", dma_cancel_req, 0);
      @(posedge clk); @(negedge clk);
      chk("R4 sets one cycle after pend", dma_cancel_req, 1);
      irq_pend = '0; settle();
   endtask

   task automatic t_resolve();
      // src1=20, src4=5, src5=5; base 8 -> min level 5 wins (R3)
      wr_lvl(1, 20); wr_lvl(4, 5); wr_lvl(5, 5); wr_base(8);
      irq_pend = 6'b110010; settle();
      chk("R3 smallest level decides", dma_cancel_req, 1);
      irq_pend = 6'b000010; settle();
      chk("R3 only larger level pending", dma_cancel_req, 0);
      // out-of-range select 7 must not touch any register (R1)
      wr_lvl(7, 0); irq_pend = 6'b000010; settle();
      chk("R1 out of range select ignored", dma_cancel_req, 0);
      wr_lvl(1, 2); settle();
      chk("R1 level write takes effect", dma_cancel_req, 1);
      irq_pend = '0; settle();
   endtask

   task automatic t_counter();
      for (int k = 0; k < 17; k++) cnt_op(1, 0, 0, 0);
      chk("R6 increment saturates at 15", cnt_level, 15);
      cnt_op(0, 1, 0, 0);
      chk("R6 decrement steps down", cnt_level, 14);
      cnt_op(1, 1, 0, 0);
      chk("R7 inc and dec together hold", cnt_level, 14);
      cnt_op(1, 0, 1, 3);
      chk("R7 write wins over increment", cnt_level, 3);
      for (int k = 0; k < 5; k++) cnt_op(0, 1, 0, 0);
      chk("R6 decrement saturates at 0", cnt_level, 0);
   endtask

   task automatic t_gate();
      dma_hold_req = 1'b1; #1;
      chk("R8 not before edge", cpu_hold_req, 0);
      @(posedge clk); @(negedge clk);
      chk("R8 passes with zero counter", cpu_hold_req, 1);
      cnt_op(1, 0, 0, 0);
      @(negedge clk);
      chk("R8 blocked by nonzero counter", cpu_hold_req, 0);
      cnt_op(0, 1, 0, 0);
      @(negedge clk);
      chk("R8 passes again after exit", cpu_hold_req, 1);
      dma_hold_req = 1'b0; @(posedge clk); @(negedge clk);
      chk("R8 follows dma release", cpu_hold_req, 0);
   endtask

   initial begin
      t_reset();
      t_disabled();
      t_cancel();
      t_resolve();
      t_counter();
      t_gate();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PER * 20000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule